// File: doc/BRIEF.md
# Read Completion Segmenter with Invalid-Start Remap

This block sits behind the inbound read path. It takes one read request at a time: a start address, a byte length, a flag that picks the coarse segment size, and a flag from an upstream decoder saying whether the start address maps to a real target. It then emits a stream of completion-status records, one per naturally aligned segment that the request's byte range covers. Segments are 64 bytes normally and 128 bytes when the coarse-segment flag is set.

Each record gives the address of the first requested byte in the segment, the number of requested bytes inside that segment, a status code and a final marker. The records come out in ascending address order over a valid/ready handshake. A request whose start address is flagged invalid is not split. It yields one record that points at the fixed legacy address 0x000C_0000, carries the unsupported-request status, reports the whole request length and is marked final. Requests are assumed never to cross a 4 KB page.

Top module: `rd_cpl_segmenter`

## Requirements
- R1: After reset, `cpl_valid` is 0 and `req_ready` is 1.
- R2: With `req_coarse`=0 and a valid start, every record covers bytes inside a single naturally aligned 64-byte block, and there is one record per 64-byte block the request touches.
- R3: With `req_coarse`=1 and a valid start, the same holds with naturally aligned 128-byte blocks.
- R4: The first record's address is the request start address. The first and last records report only the bytes that fall inside the request, so the byte counts of all records add up to the request length.
- R5: Records appear in ascending order. Each non-final record's address plus its byte count equals the next record's address.
- R6: `cpl_last` is 1 on the final record of a request and 0 on every other record.
- R7: With `req_start_ok`=0, exactly one record is produced, with `cpl_addr`=0x000C_0000, `cpl_status`=2'b01 (unsupported request), `cpl_last`=1 and `cpl_bytes` equal to the effective request length.
- R8: With `req_start_ok`=1, every record carries `cpl_status`=2'b00 (normal completion).
- R9: `req_ready` is 0 from the cycle a request is accepted until its final record is taken. It is 1 again in the cycle after that.
- R10: A request with `req_len`=0 is handled as a 1-byte access at its start address.
- R11: While `cpl_valid`=1 and `cpl_ready`=0, all record outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Segmenter idle, request may be taken |
| req_addr | input | ADDR_W | Request start byte address |
| req_len | input | LEN_W | Request length in bytes (0 means 1) |
| req_coarse | input | 1 | 1 selects 128-byte segments, 0 selects 64-byte segments |
| req_start_ok | input | 1 | Start address hits a valid target |
| cpl_valid | output | 1 | Record available |
| cpl_ready | input | 1 | Consumer takes the record |
| cpl_addr | output | ADDR_W | Address of first requested byte in segment, or remap address |
| cpl_bytes | output | LEN_W | Requested bytes covered by this record |
| cpl_status | output | 2 | 2'b00 normal, 2'b01 unsupported request |
| cpl_last | output | 1 | Final record of the request |

## Verification
The bench sweeps start offsets across two 128-byte windows against lengths placed just below, on and just above each segment size, in both segment modes. This exposes an off-by-one in the segment end, which would emit an extra zero-byte record or merge two blocks. It also exposes a wrong alignment mask, which would split at the wrong granule in the mode not intended. Zero-length requests check that the length-minus-one arithmetic does not wrap into a 4 KB span. Invalid-start requests of several lengths check that the remap yields one final unsupported record instead of a segmented run. Ready is stalled in a fixed pattern, so a design that advanced without the handshake, or that reopened `req_ready` early, would lose or repeat records.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  typedef enum logic [1:0] {
    CPL_OK = 2'b00,
    CPL_UR = 2'b01
  } cpl_status_e;
endpackage

// File: rtl/rcs_seg_math.sv
module rcs_seg_math
  import rcs_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned LEN_W    = 13,
  parameter int unsigned FINE_B   = 64,
  parameter int unsigned COARSE_B = 128,
  parameter logic [ADDR_W-1:0] REMAP_ADDR = 32'h000C_0000
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [ADDR_W-1:0] end_addr,
  input  logic [LEN_W-1:0]  full_len,
  input  logic              coarse,
  input  logic              start_ok,
  output logic [ADDR_W-1:0] seg_addr,
  output logic [LEN_W-1:0]  seg_bytes,
  output logic [1:0]        seg_status,
  output logic              seg_last,
  output logic [ADDR_W-1:0] seg_next
);
  localparam logic [ADDR_W-1:0] FINE_MASK   = ADDR_W'(FINE_B - 1);
  localparam logic [ADDR_W-1:0] COARSE_MASK = ADDR_W'(COARSE_B - 1);

  logic [ADDR_W-1:0] blk_end;
  logic [ADDR_W-1:0] stop_addr;
  logic [ADDR_W-1:0] span;
  logic              reach_end;

  always_comb begin
    blk_end   = cur_addr | (coarse ? COARSE_MASK : FINE_MASK);
    reach_end = (blk_end >= end_addr);
    stop_addr = reach_end ? end_addr : blk_end;
    span      = stop_addr - cur_addr;
    seg_next  = blk_end + ADDR_W'(1);
    if (start_ok) begin
      seg_addr   = cur_addr;
      seg_bytes  = span[LEN_W-1:0] + LEN_W'(1);
      seg_status = CPL_OK;
      seg_last   = reach_end;
    end else begin
      seg_addr   = REMAP_ADDR;
      seg_bytes  = full_len;
      seg_status = CPL_UR;
      seg_last   = 1'b1;
    end
  end
endmodule

// File: rtl/rcs_seq.sv
module rcs_seq
  import rcs_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned LEN_W    = 13,
  parameter int unsigned FINE_B   = 64,
  parameter int unsigned COARSE_B = 128,
  parameter logic [ADDR_W-1:0] REMAP_ADDR = 32'h000C_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_coarse,
  input  logic              req_start_ok,
  input  logic              cpl_ready,
  output logic              cpl_valid,
  output logic [ADDR_W-1:0] cur_q,
  output logic [ADDR_W-1:0] end_q,
  output logic [LEN_W-1:0]  len_q,
  output logic              coarse_q,
  output logic              ok_q,
  input  logic [ADDR_W-1:0] seg_addr,
  input  logic [LEN_W-1:0]  seg_bytes,
  input  logic [1:0]        seg_status,
  input  logic              seg_last,
  input  logic [ADDR_W-1:0] seg_next
);
  localparam int unsigned FINE_SH   = $clog2(FINE_B);
  localparam int unsigned COARSE_SH = $clog2(COARSE_B);

  logic              busy_q, busy_d;
  logic [ADDR_W-1:0] cur_d, end_d;
  logic [LEN_W-1:0]  len_d, eff_len;
  logic              coarse_d, ok_d;
  logic              ld_en, adv_en;

  assign req_ready = ~busy_q;
  assign cpl_valid = busy_q;

  always_comb begin
    ld_en    = ~busy_q & req_valid;
    adv_en   = busy_q & cpl_ready;
    eff_len  = (req_len == '0) ? LEN_W'(1) : req_len;
    busy_d   = busy_q;
    cur_d    = cur_q;
    end_d    = end_q;
    len_d    = len_q;
    coarse_d = coarse_q;
    ok_d     = ok_q;
    if (ld_en) begin
      busy_d   = 1'b1;
      cur_d    = req_addr;
      end_d    = req_addr + ADDR_W'(eff_len) - ADDR_W'(1);
      len_d    = eff_len;
      coarse_d = req_coarse;
      ok_d     = req_start_ok;
    end else if (adv_en) begin
      if (seg_last) busy_d = 1'b0;
      else          cur_d  = seg_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      cur_q    <= '0;
      end_q    <= '0;
      len_q    <= '0;
      coarse_q <= 1'b0;
      ok_q     <= 1'b0;
    end else begin
      busy_q <= busy_d;
      if (ld_en || adv_en) cur_q <= cur_d;
      if (ld_en) begin
        end_q    <= end_d;
        len_q    <= len_d;
        coarse_q <= coarse_d;
        ok_q     <= ok_d;
      end
    end
  end

  assert_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |-> !req_ready);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && !cpl_ready) |=> (cpl_valid && $stable(seg_addr) &&
      $stable(seg_bytes) && $stable(seg_last) && $stable(seg_status)));

  assert_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && cpl_ready && !seg_last) |=>
      (cpl_valid && seg_addr == $past(seg_addr) + ADDR_W'($past(seg_bytes))));

  assert_remap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && seg_status == CPL_UR) |-> (seg_last && seg_addr == REMAP_ADDR));

  assert_fine_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && ok_q && !coarse_q) |->
      (((seg_addr ^ (seg_addr + ADDR_W'(seg_bytes) - ADDR_W'(1))) >> FINE_SH) == '0));

  assert_coarse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && ok_q && coarse_q) |->
      (((seg_addr ^ (seg_addr + ADDR_W'(seg_bytes) - ADDR_W'(1))) >> COARSE_SH) == '0));

  assert_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && ok_q) |-> (seg_status == CPL_OK && seg_bytes != '0));
endmodule

// File: rtl/rd_cpl_segmenter.sv
module rd_cpl_segmenter
  import rcs_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned LEN_W    = 13,
  parameter int unsigned FINE_B   = 64,
  parameter int unsigned COARSE_B = 128,
  parameter logic [ADDR_W-1:0] REMAP_ADDR = 32'h000C_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_coarse,
  input  logic              req_start_ok,
  output logic              cpl_valid,
  input  logic              cpl_ready,
  output logic [ADDR_W-1:0] cpl_addr,
  output logic [LEN_W-1:0]  cpl_bytes,
  output logic [1:0]        cpl_status,
  output logic              cpl_last
);
  logic [ADDR_W-1:0] cur_q, end_q, seg_next;
  logic [LEN_W-1:0]  len_q;
  logic              coarse_q, ok_q;

  rcs_seq #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .FINE_B(FINE_B),
    .COARSE_B(COARSE_B), .REMAP_ADDR(REMAP_ADDR)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len),
    .req_coarse(req_coarse), .req_start_ok(req_start_ok),
    .cpl_ready(cpl_ready), .cpl_valid(cpl_valid),
    .cur_q(cur_q), .end_q(end_q), .len_q(len_q),
    .coarse_q(coarse_q), .ok_q(ok_q),
    .seg_addr(cpl_addr), .seg_bytes(cpl_bytes), .seg_status(cpl_status),
    .seg_last(cpl_last), .seg_next(seg_next)
  );

  rcs_seg_math #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .FINE_B(FINE_B),
    .COARSE_B(COARSE_B), .REMAP_ADDR(REMAP_ADDR)
  ) u_math (
    .cur_addr(cur_q), .end_addr(end_q), .full_len(len_q),
    .coarse(coarse_q), .start_ok(ok_q),
    .seg_addr(cpl_addr), .seg_bytes(cpl_bytes), .seg_status(cpl_status),
    .seg_last(cpl_last), .seg_next(seg_next)
  );
endmodule

// File: tb/test_rd_cpl_segmenter.sv
module test_rd_cpl_segmenter;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int LW = 13;
  localparam logic [31:0] REMAP = 32'h000C_0000;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, req_coarse, req_start_ok;
  logic [AW-1:0] req_addr;
  logic [LW-1:0] req_len;
  logic cpl_valid, cpl_ready, cpl_last;
  logic [AW-1:0] cpl_addr;
  logic [LW-1:0] cpl_bytes;
  logic [1:0] cpl_status;

  int n_run = 0;
  int n_fail = 0;
  int stall_ctr = 0;
  int cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rd_cpl_segmenter i_rd_cpl_segmenter (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len),
    .req_coarse(req_coarse), .req_start_ok(req_start_ok),
    .cpl_valid(cpl_valid), .cpl_ready(cpl_ready),
    .cpl_addr(cpl_addr), .cpl_bytes(cpl_bytes),
    .cpl_status(cpl_status), .cpl_last(cpl_last)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run did not finish (actual hung, expected completion)");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // R2 R3 R4 R5 R6 R7 R8 R9 R10 R11: drive one request and check every record
  task automatic run_req(input logic [31:0] a, input int len, input bit coarse, input bit ok);
    int eff;
    logic [31:0] cur, endA, se, stopA;
    int gm;
    bit lst;
    int eb;
    int sum;
    @(negedge clk);
    chk(req_ready === 1'b1, "R9 ready before request", req_ready, 1);
    req_valid = 1'b1; req_addr = a; req_len = LW'(len);
    req_coarse = coarse; req_start_ok = ok;
    @(negedge clk);
    req_valid = 1'b0; req_addr = '0; req_len = '0; req_coarse = 1'b0; req_start_ok = 1'b0;
    eff = (len == 0) ? 1 : len;   // R10
    gm = coarse ? 127 : 63;
    cur = a; endA = a + eff - 1; sum = 0;
    lst = 0;
    while (!lst) begin
      if (ok) begin
        se = cur | gm;
        lst = (se >= endA);
        stopA = lst ? endA : se;
        eb = int'(stopA - cur) + 1;
      end else begin
        lst = 1; eb = eff;
      end
      // stall a fixed pattern, record must hold (R11)
      forever begin
        stall_ctr++;
        cpl_ready = (stall_ctr % 4) != 3;
        if (!cpl_valid || req_ready) begin
          chk(0, "R9 record present, ready low", {cpl_valid, req_ready}, 2'b10);
          break;
        end
        if (cpl_ready) break;
        @(negedge clk);
      end
      chk(cpl_addr === (ok ? cur : REMAP), ok ? (coarse ? "R3 addr" : "R2 addr") : "R7 remap addr", cpl_addr, ok ? cur : REMAP);
      chk(cpl_bytes === LW'(eb), ok ? "R4 bytes" : "R7 bytes", cpl_bytes, eb);
      chk(cpl_status === (ok ? 2'b00 : 2'b01), ok ? "R8 status" : "R7 status", cpl_status, ok ? 0 : 1);
      chk(cpl_last === lst, "R6 last marker", cpl_last, lst);
      sum += eb;
      if (ok && !lst) cur = se + 1;  // R5 next address
      @(negedge clk);
      cpl_ready = 1'b0;
      if (!cpl_last && cpl_valid === 1'b0 && !lst) begin
        chk(0, "R5 next record missing", 0, 1);
        lst = 1;
      end
    end
    chk(sum == eff, "R4 total bytes", sum, eff);
    chk(req_ready === 1'b1 && cpl_valid === 1'b0, "R9 idle after final", {req_ready, cpl_valid}, 2'b10);
  endtask

  initial begin
    int lens[13] = '{0, 1, 2, 31, 63, 64, 65, 127, 128, 129, 191, 256, 300};
    rst_n = 1'b0; req_valid = 0; req_addr = '0; req_len = '0;
    req_coarse = 0; req_start_ok = 0; cpl_ready = 0;
    repeat (3) @(negedge clk);
    chk(cpl_valid === 1'b0, "R1 cpl_valid reset", cpl_valid, 0);
    chk(req_ready === 1'b1, "R1 req_ready reset", req_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cpl_valid === 1'b0 && req_ready === 1'b1, "R1 idle after release", {cpl_valid, req_ready}, 2'b01);
    for (int c = 0; c < 2; c++)
      for (int off = 0; off < 256; off += 5)
        foreach (lens[k])
          run_req(32'h4000_1000 + off, lens[k], c[0], 1'b1);
    // R7 invalid start, several lengths and both modes
    foreach (lens[k]) begin
      run_req(32'h8000_0040 + k, lens[k], k[0], 1'b0);
    end
    // R10 zero length at end of a block, R2 exact block boundaries
    run_req(32'h0000_203F, 0, 1'b0, 1'b1);
    run_req(32'h0000_207F, 0, 1'b1, 1'b1);
    run_req(32'h0000_2000, 4096, 1'b1, 1'b1);
    run_req(32'h0000_3FC0, 64, 1'b0, 1'b1);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule